// File: doc/BRIEF.md
# Segmented DAC Switch-Control Front End

This block is the digital front end of a 16-bit segmented current-steering converter. The upper four bits of the input code become fifteen equal-weight unit-cell controls in thermometer form. The lower twelve bits pass through undecoded and drive the binary-weighted cells.

All 27 controls pass through one level-sensitive latch that is enabled by the clock. While the clock is high, the latch is transparent and the controls follow the code. The falling edge captures the code, and the controls keep that value until the clock rises again. There is no second register stage, so a data change reaches the outputs within half a clock period.

Every cell is always conducting. Its control only chooses which leg carries its current, so each cell is given a true and a complement steering signal. For checking, the block also provides a behavioural sum of the current on each leg, counted in LSB units. A unit cell weighs 4096 and binary cell k weighs 2^k.

Top module: `segdac_front`

## Requirements
- R1: Unit cell i (i = 0..14) is steered to the true leg, `unit_t[i]` = 1, exactly when the upper nibble `code[15:12]` is greater than i. A nibble value N therefore turns on exactly N cells.
- R2: Binary control `bin_t[k]` equals `code[k]` for k = 0..11, with no decoding.
- R3: Each complement steering signal is the inverse of its true signal: `unit_c` = ~`unit_t` and `bin_c` = ~`bin_t`.
- R4: While `clk` is high, the outputs follow a change of `code` within the same high phase, without waiting for a clock edge.
- R5: The code present at a falling edge of `clk` is held on all outputs while `clk` stays low. Changes of `code` during the low phase have no effect on the outputs.
- R6: `leg_t` equals 4096 times the number of unit cells on the true leg, plus the true binary bits weighted 2^k. `leg_c` is the same sum taken over the complement signals, so `leg_t` + `leg_c` = 65535.
- R7: Code 0 gives `leg_t` = 0 and `leg_c` = 65535. Code 65535 gives the reverse. Code 32768 gives legs that differ by exactly one LSB (32768 and 32767).
- R8: While `rst_n` is low, regardless of `clk`, the latched code is forced to 0: all true controls are 0, `leg_t` = 0 and `leg_c` = 65535.
- R9: Unit-cell selection is monotonic: whenever cell i is on, every cell below i is also on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Latch enable: high = track, low = hold |
| rst_n | input | 1 | Active-low asynchronous clear of the latch |
| code | input | 16 | Input code, unsigned |
| unit_t | output | 15 | Unit-cell controls for the true leg |
| unit_c | output | 15 | Unit-cell controls for the complement leg |
| bin_t | output | 12 | Binary-cell controls for the true leg |
| bin_c | output | 12 | Binary-cell controls for the complement leg |
| leg_t | output | 16 | Behavioural current on the true leg, in LSB |
| leg_c | output | 16 | Behavioural current on the complement leg, in LSB |

## Verification
Two events can meet in the same clock cycle: a new code arriving and the latch closing on the falling edge.

The bench changes the code one nanosecond after a falling edge and samples again before the next rising edge. It expects the value captured at the edge, not the new one. After the rising edge it expects the new code to appear in the same high phase.

It also asserts reset during a transparent phase while a nonzero code is applied. The outputs must clear at once, even though the latch is open.

// File: rtl/segdac_front.sv
module segdac_front #(
  parameter int THERM_BITS = 4,
  parameter int BIN_BITS   = 12
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [THERM_BITS+BIN_BITS-1:0]       code,
  output logic [(1<<THERM_BITS)-2:0]           unit_t,
  output logic [(1<<THERM_BITS)-2:0]           unit_c,
  output logic [BIN_BITS-1:0]                  bin_t,
  output logic [BIN_BITS-1:0]                  bin_c,
  output logic [THERM_BITS+BIN_BITS-1:0]       leg_t,
  output logic [THERM_BITS+BIN_BITS-1:0]       leg_c
);
  localparam int CELLS = (1 << THERM_BITS) - 1;
  localparam int W     = THERM_BITS + BIN_BITS;

  logic [THERM_BITS-1:0] nib;
  logic [CELLS-1:0]      therm_d, therm_q;
  logic [BIN_BITS-1:0]   bin_q;
  logic [THERM_BITS-1:0] cnt_t, cnt_c;

  assign nib = code[W-1:BIN_BITS];

  for (genvar i = 0; i < CELLS; i++) begin : g_dec
    assign therm_d[i] = (32'(nib) > i);
  end

  always_latch begin
    if (!rst_n) begin
      therm_q <= '0;
      bin_q   <= '0;
    end else if (clk) begin
      therm_q <= therm_d;
      bin_q   <= code[BIN_BITS-1:0];
    end
  end

  assign unit_t = therm_q;
  assign unit_c = ~therm_q;
  assign bin_t  = bin_q;
  assign bin_c  = ~bin_q;

  always_comb begin
    cnt_t = '0;
    cnt_c = '0;
    for (int i = 0; i < CELLS; i++) begin
      cnt_t = cnt_t + THERM_BITS'(unit_t[i]);
      cnt_c = cnt_c + THERM_BITS'(unit_c[i]);
    end
  end

  assign leg_t = {cnt_t, bin_t};
  assign leg_c = {cnt_c, bin_c};

  logic [W-1:0] snap;
  logic         snap_v;
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap   <= '0;
      snap_v <= 1'b0;
    end else begin
      snap   <= code;
      snap_v <= 1'b1;
    end
  end

  // R9
  therm_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_t & (unit_t + CELLS'(1))) == '0);

  // R6
  leg_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, leg_t} + {1'b0, leg_c}) == {1'b0, {W{1'b1}}});

  // R5
  hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_v |-> leg_t == snap);

  // R4
  track_value_chk: assert property (@(negedge clk) disable iff (!rst_n)
    leg_t == code);
endmodule

// File: tb/segdac_front_tb_top.sv
module segdac_front_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] code = '0;
  logic [14:0] unit_t, unit_c;
  logic [11:0] bin_t, bin_c;
  logic [15:0] leg_t, leg_c;
  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  segdac_front dut_i (.clk(clk), .rst_n(rst_n), .code(code),
    .unit_t(unit_t), .unit_c(unit_c), .bin_t(bin_t), .bin_c(bin_c),
    .leg_t(leg_t), .leg_c(leg_c));

  always #5 clk = ~clk;

  function automatic logic [14:0] exp_unit(input logic [15:0] c);
    logic [14:0] r;
    for (int i = 0; i < 15; i++) r[i] = (int'(c[15:12]) > i);
    return r;
  endfunction

  task automatic check(input logic [15:0] e, input string tag);
    logic [14:0] eu;
    eu = exp_unit(e);
    vecs++;
    if (unit_t !== eu) begin errs++; $display("FAIL %s R1 unit_t=%h exp=%h", tag, unit_t, eu); end
    if (bin_t !== e[11:0]) begin errs++; $display("FAIL %s R2 bin_t=%h exp=%h", tag, bin_t, e[11:0]); end
    if (unit_c !== ~eu || bin_c !== ~e[11:0]) begin
      errs++; $display("FAIL %s R3 unit_c=%h bin_c=%h exp=%h %h", tag, unit_c, bin_c, ~eu, ~e[11:0]);
    end
    if (leg_t !== e || leg_c !== 16'hFFFF - e) begin
      errs++; $display("FAIL %s R6 leg_t=%0d leg_c=%0d exp=%0d %0d", tag, leg_t, leg_c, e, 16'hFFFF - e);
    end
  endtask

  task automatic track(input logic [15:0] v, input string tag);
    @(posedge clk); #1 code = v; #1 check(v, tag);
  endtask

  task automatic hold_cycle(input logic [15:0] a, input logic [15:0] b);
    track(a, "R4 track");
    @(negedge clk); #1 code = b; #2 check(a, "R5 hold");
    @(posedge clk); #1 check(b, "R4 after rise");
  endtask

  initial begin
    void'($urandom(32'd1234));
    #3 check(16'h0000, "R8 reset clk low");
    @(posedge clk); #1 code = 16'hBEEF; #1 check(16'h0000, "R8 reset clk high");
    rst_n = 1'b1; #1 check(16'hBEEF, "R4 release");
    track(16'h0000, "R7 zero");
    track(16'hFFFF, "R7 full");
    track(16'h8000, "R7 mid");
    if (leg_t - leg_c !== 16'd1) begin errs++; $display("FAIL R7 mid diff=%0d exp=1", leg_t - leg_c); end
    vecs++;
    for (int n = 0; n < 16; n++) track({n[3:0], 12'h5A3}, "R1 R9 nibble");
    for (int k = 0; k < 12; k++) track(16'(1 << k), "R2 bit");
    hold_cycle(16'h1234, 16'hFEDC);
    hold_cycle(16'hF000, 16'h0FFF);
    @(posedge clk); #1 code = 16'h4321; #1 check(16'h4321, "R4 first");
    #2 code = 16'h9876; #1 check(16'h9876, "R4 second in phase");
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a, b;
      a = 16'($urandom); b = 16'($urandom);
      hold_cycle(a, b);
    end
    @(posedge clk); #1 code = 16'hA5A5; #1 rst_n = 1'b0; #1 check(16'h0000, "R8 async");
    @(negedge clk); #1 rst_n = 1'b1; #1 check(16'h0000, "R8 release low");
    @(posedge clk); #1 check(16'hA5A5, "R4 after reset");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule